// File: doc/BRIEF.md
# Per-Instruction Invoke Predictor

This block is a small fully associative table in the fetch stage. For each load or store instruction address, it predicts whether that instruction will trigger a transactional-tracking call. Fetch presents an instruction address and gets back a single predict bit from combinational logic. Later, a resolve port reports whether the instruction was predicted and whether it actually triggered. The table then allocates, advances, promotes or removes the entry for that address.

Each entry is one 32-bit word plus a valid bit. The upper 30 bits hold the word-aligned instruction address, and the two always-zero low bits hold a 2-bit class/state code. The code separates two kinds of instruction:

- instructions that touch the same stripe every time;
- instructions that touch a different stripe each time.

Entries are not trained as saturating counters. Instead, a transaction-start pulse rearms them. A context-switch pulse empties the table.

Top module: `invoke_predictor`

## Requirements
- R1: After reset no entry is valid, so `fetch_predict` is 0 for every address.
- R2: The 2-bit code means 0 = same-stripe idle, 1 = same-stripe done, 2 = multi-stripe idle, 3 = multi-stripe done. `fetch_predict` is 1 when a valid entry matches the address and its code is 0, 2 or 3. It is 0 when nothing matches or the code is 1.
- R3: A resolve with `res_triggered`=1 for an address that has no entry allocates one entry with code 1. An address never occupies two entries.
- R4: A resolve with `res_triggered`=1 that hits an entry moves code 0 to 1 and code 2 to 3, and leaves code 3 unchanged.
- R5: A resolve with `res_triggered`=1 that hits an entry at code 1 promotes it to code 3.
- R6: A resolve with `res_triggered`=0 and `res_predicted`=1 removes the matching entry. A resolve with both flags 0 changes nothing.
- R7: `txn_start` resets every valid entry at code 1 to 0 and every valid entry at code 3 to 2.
- R8: `ctx_flush` invalidates all entries.
- R9: When pulses coincide, `ctx_flush` wins over `txn_start`, and `txn_start` wins over a resolve update. The losing actions of that cycle are discarded.
- R10: Allocation uses the lowest-numbered invalid slot. When all 16 slots are valid, it replaces the slot under a round-robin pointer. That pointer starts at slot 0 and advances by one after each replacement.
- R11: Address bits [1:0] are ignored on both the fetch port and the resolve port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | 32 | Instruction address looked up by fetch |
| fetch_predict | output | 1 | Trigger prediction for `fetch_pc` |
| res_valid | input | 1 | Resolve report present this cycle |
| res_pc | input | 32 | Address of the resolved instruction |
| res_predicted | input | 1 | Fetch predicted a trigger for it |
| res_triggered | input | 1 | It actually triggered a call |
| txn_start | input | 1 | Transaction-start pulse (rearm) |
| ctx_flush | input | 1 | Context-switch pulse (invalidate all) |

## Verification
The hardest case to reach from the ports is round-robin replacement, because it only happens once every slot is valid. The bench first empties the table with a flush. It then allocates sixteen distinct addresses and rearms them with a start pulse, so that each live entry shows up as a 1 on the predict output. After that, every further allocation must evict a specific, predictable address.

Removing one entry from a full table then shows that a freed slot is reused ahead of the round-robin victim. Absence is told apart from code 1 by issuing a start pulse before each check.

// File: rtl/invp_pkg.sv
package invp_pkg;

    localparam int PC_W   = 32;
    localparam int CODE_W = 2;
    localparam int TAG_W  = PC_W - CODE_W;

    typedef enum logic [CODE_W-1:0] {
        ONE_IDLE   = 2'd0,
        ONE_DONE   = 2'd1,
        MULTI_IDLE = 2'd2,
        MULTI_DONE = 2'd3
    } code_e;

    function automatic logic [PC_W-1:0] pack_word(input logic [PC_W-1:0] pc, input code_e c);
        return {pc[PC_W-1:CODE_W], c};
    endfunction

    function automatic code_e word_code(input logic [PC_W-1:0] w);
        return code_e'(w[CODE_W-1:0]);
    endfunction

    // Next code when a resolved instruction triggered and hit its entry.
    function automatic code_e code_on_trigger(input code_e c);
        case (c)
            ONE_IDLE: return ONE_DONE;
            default:  return MULTI_DONE;
        endcase
    endfunction

    function automatic code_e code_on_start(input code_e c);
        case (c)
            ONE_DONE:   return ONE_IDLE;
            MULTI_DONE: return MULTI_IDLE;
            default:    return c;
        endcase
    endfunction

    function automatic logic code_predicts(input code_e c);
        return c != ONE_DONE;
    endfunction

endpackage

// File: rtl/invp_lookup.sv
module invp_lookup
    import invp_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]           valid_vec,
    input  logic [ENTRIES-1:0][PC_W-1:0] words,
    input  logic [PC_W-1:0]              pc,
    output logic [ENTRIES-1:0]           hit_vec,
    output logic                         hit_any,
    output logic [IDX_W-1:0]             hit_idx,
    output code_e                        hit_code
);
    logic unused_low_bits;
    assign unused_low_bits = ^pc[CODE_W-1:0];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = valid_vec[g] && (words[g][PC_W-1:CODE_W] == pc[PC_W-1:CODE_W]);
    end

    assign hit_any = |hit_vec;

    always_comb begin
        hit_idx  = '0;
        hit_code = ONE_IDLE;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) begin
                hit_idx  = IDX_W'(i);
                hit_code = word_code(words[i]);
            end
        end
    end
endmodule

// File: rtl/invp_victim.sv
module invp_victim #(
    parameter int ENTRIES = 16,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic               alloc,
    output logic [IDX_W-1:0]   slot
);
    logic [IDX_W-1:0] rr_ptr;
    logic [IDX_W-1:0] first_free;
    logic             full;

    assign full = &valid_vec;

    always_comb begin
        first_free = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) first_free = IDX_W'(i);
        end
    end

    assign slot = full ? rr_ptr : first_free;

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_ptr <= '0;
        end else if (alloc && full) begin
            rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
        end
    end
endmodule

// File: rtl/invoke_predictor.sv
module invoke_predictor
    import invp_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] fetch_pc,
    output logic            fetch_predict,
    input  logic            res_valid,
    input  logic [PC_W-1:0] res_pc,
    input  logic            res_predicted,
    input  logic            res_triggered,
    input  logic            txn_start,
    input  logic            ctx_flush
);
    logic [ENTRIES-1:0]           valid_vec;
    logic [ENTRIES-1:0][PC_W-1:0] words;

    logic [ENTRIES-1:0] f_hit_vec;
    logic               f_hit;
    logic [IDX_W-1:0]   f_idx;
    code_e              f_code;

    logic [ENTRIES-1:0] r_hit_vec;
    logic               r_hit;
    logic [IDX_W-1:0]   r_idx;
    code_e              r_code;

    logic [IDX_W-1:0] alloc_slot;
    logic             upd_ok;
    logic             do_alloc;
    logic             do_bump;
    logic             do_remove;

    invp_lookup #(.ENTRIES(ENTRIES)) fetch_lu_i (
        .valid_vec(valid_vec), .words(words), .pc(fetch_pc),
        .hit_vec(f_hit_vec), .hit_any(f_hit), .hit_idx(f_idx), .hit_code(f_code)
    );

    invp_lookup #(.ENTRIES(ENTRIES)) res_lu_i (
        .valid_vec(valid_vec), .words(words), .pc(res_pc),
        .hit_vec(r_hit_vec), .hit_any(r_hit), .hit_idx(r_idx), .hit_code(r_code)
    );

    assign fetch_predict = f_hit && code_predicts(f_code);

    // Flush over start over resolve update.
    assign upd_ok    = res_valid && !txn_start && !ctx_flush;
    assign do_alloc  = upd_ok && res_triggered && !r_hit;
    assign do_bump   = upd_ok && res_triggered && r_hit;
    assign do_remove = upd_ok && !res_triggered && res_predicted && r_hit;

    invp_victim #(.ENTRIES(ENTRIES)) victim_i (
        .clk(clk), .rst(rst), .valid_vec(valid_vec), .alloc(do_alloc), .slot(alloc_slot)
    );

    logic unused_idx;
    assign unused_idx = ^{f_idx, f_hit_vec, r_hit_vec};

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_vec <= '0;
            words     <= '0;
        end else if (ctx_flush) begin
            valid_vec <= '0;
        end else if (txn_start) begin
            for (int i = 0; i < ENTRIES; i++) begin
                words[i] <= pack_word(words[i], code_on_start(word_code(words[i])));
            end
        end else if (do_alloc) begin
            valid_vec[alloc_slot] <= 1'b1;
            words[alloc_slot]     <= pack_word(res_pc, ONE_DONE);
        end else if (do_bump) begin
            words[r_idx] <= pack_word(words[r_idx], code_on_trigger(r_code));
        end else if (do_remove) begin
            valid_vec[r_idx] <= 1'b0;
        end
    end
endmodule

// File: rtl/invp_checker.sv
module invp_checker
    import invp_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         fetch_predict,
    input logic                         res_valid,
    input logic                         res_predicted,
    input logic                         res_triggered,
    input logic                         txn_start,
    input logic                         ctx_flush,
    input logic                         r_hit,
    input logic [ENTRIES-1:0]           f_hit_vec,
    input logic [ENTRIES-1:0]           valid_vec,
    input logic [ENTRIES-1:0][PC_W-1:0] words
);
    logic odd_live;
    always_comb begin
        odd_live = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (valid_vec[i] && words[i][0]) odd_live = 1'b1;
        end
    end

    logic alloc_ev, remove_ev;
    assign alloc_ev  = res_valid && res_triggered && !r_hit && !txn_start && !ctx_flush;
    assign remove_ev = res_valid && !res_triggered && res_predicted && r_hit && !txn_start && !ctx_flush;

    assert_unique_hit_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(f_hit_vec));

    assert_flush_empty_R8: assert property (@(posedge clk) disable iff (rst)
        ctx_flush |=> (valid_vec == '0) && !fetch_predict);

    assert_rearm_even_R7: assert property (@(posedge clk) disable iff (rst)
        (txn_start && !ctx_flush) |=> !odd_live);

    assert_alloc_grows_R10: assert property (@(posedge clk) disable iff (rst)
        alloc_ev |=> ($countones(valid_vec) == $past($countones(valid_vec)) + 1)
                     || ($past($countones(valid_vec)) == ENTRIES));

    assert_remove_shrinks_R6: assert property (@(posedge clk) disable iff (rst)
        remove_ev |=> $countones(valid_vec) == $past($countones(valid_vec)) - 1);
endmodule

bind invoke_predictor invp_checker #(.ENTRIES(ENTRIES)) chk_i (
    .clk(clk), .rst(rst), .fetch_predict(fetch_predict), .res_valid(res_valid),
    .res_predicted(res_predicted), .res_triggered(res_triggered), .txn_start(txn_start),
    .ctx_flush(ctx_flush), .r_hit(r_hit), .f_hit_vec(f_hit_vec),
    .valid_vec(valid_vec), .words(words)
);

// File: tb/invoke_predictor_tb.sv
module invoke_predictor_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] fetch_pc = '0;
    logic        fetch_predict;
    logic        res_valid = 1'b0;
    logic [31:0] res_pc = '0;
    logic        res_predicted = 1'b0;
    logic        res_triggered = 1'b0;
    logic        txn_start = 1'b0;
    logic        ctx_flush = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    invoke_predictor dut_i (
        .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .fetch_predict(fetch_predict),
        .res_valid(res_valid), .res_pc(res_pc), .res_predicted(res_predicted),
        .res_triggered(res_triggered), .txn_start(txn_start), .ctx_flush(ctx_flush)
    );

    // One clock with the given controls, ending at a falling edge.
    task automatic step(input logic rv, input logic [31:0] pc, input logic pred,
                        input logic trig, input logic st, input logic fl);
        @(negedge clk);
        res_valid = rv; res_pc = pc; res_predicted = pred; res_triggered = trig;
        txn_start = st; ctx_flush = fl;
        @(negedge clk);
        res_valid = 1'b0; res_predicted = 1'b0; res_triggered = 1'b0;
        txn_start = 1'b0; ctx_flush = 1'b0;
    endtask

    task automatic resolve(input logic [31:0] pc, input logic pred, input logic trig);
        step(1'b1, pc, pred, trig, 1'b0, 1'b0);
    endtask

    task automatic start_txn();
        step(1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic flush();
        step(1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic expect_pred(input logic [31:0] pc, input logic exp, input string req);
        fetch_pc = pc;
        #1;
        checks++;
        if (fetch_predict !== exp) begin
            errors++;
            $display("FAIL %s pc=%h predict actual=%b expected=%b", req, pc, fetch_predict, exp);
        end
    endtask

    task automatic t_reset();
        expect_pred(32'h0000_1000, 1'b0, "R1");
        expect_pred(32'h0000_0000, 1'b0, "R1");
    endtask

    task automatic t_single_stripe();
        resolve(32'h100, 1'b0, 1'b1);
        expect_pred(32'h100, 1'b0, "R3");          // code 1
        start_txn();
        expect_pred(32'h100, 1'b1, "R7");          // code 0
        expect_pred(32'h103, 1'b1, "R11");
        resolve(32'h100, 1'b1, 1'b1);
        expect_pred(32'h100, 1'b0, "R4");          // 0 -> 1
    endtask

    task automatic t_multi_stripe();
        resolve(32'h100, 1'b0, 1'b1);              // 1 -> 3
        expect_pred(32'h100, 1'b1, "R5");
        start_txn();
        expect_pred(32'h100, 1'b1, "R7");          // 2
        resolve(32'h102, 1'b1, 1'b1);              // 2 -> 3, low bits differ
        expect_pred(32'h100, 1'b1, "R4");
        resolve(32'h100, 1'b1, 1'b1);              // 3 stays
        expect_pred(32'h100, 1'b1, "R4");
        start_txn();
        expect_pred(32'h100, 1'b1, "R2");
    endtask

    task automatic t_remove();
        resolve(32'h100, 1'b1, 1'b0);
        expect_pred(32'h100, 1'b0, "R6");
        start_txn();
        expect_pred(32'h100, 1'b0, "R6");          // absent, not code 1
        resolve(32'h200, 1'b0, 1'b1);              // code 1
        resolve(32'h200, 1'b0, 1'b0);              // no effect
        start_txn();
        expect_pred(32'h200, 1'b1, "R6");          // still there
    endtask

    task automatic t_flush_and_priority();
        resolve(32'h300, 1'b0, 1'b1);
        resolve(32'h300, 1'b0, 1'b1);              // code 3
        expect_pred(32'h300, 1'b1, "R5");
        flush();
        expect_pred(32'h300, 1'b0, "R8");
        expect_pred(32'h200, 1'b0, "R8");
        step(1'b1, 32'h400, 1'b0, 1'b1, 1'b1, 1'b0);   // start drops update
        start_txn();
        expect_pred(32'h400, 1'b0, "R9");
        resolve(32'h500, 1'b0, 1'b1);              // code 1
        step(1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 1'b1); // flush beats start
        start_txn();
        expect_pred(32'h500, 1'b0, "R9");
        resolve(32'h600, 1'b0, 1'b1);              // code 1
        step(1'b1, 32'h600, 1'b0, 1'b1, 1'b1, 1'b0); // start wins, 1 -> 0, no promote
        expect_pred(32'h600, 1'b1, "R9");
        resolve(32'h600, 1'b1, 1'b1);              // 0 -> 1 proves code was 0
        expect_pred(32'h600, 1'b0, "R9");
    endtask

    task automatic t_replace();
        flush();
        for (int i = 0; i < 16; i++) resolve(32'h1000 + 32'(i) * 4, 1'b0, 1'b1);
        start_txn();
        for (int i = 0; i < 16; i++) expect_pred(32'h1000 + 32'(i) * 4, 1'b1, "R10");
        resolve(32'h2000, 1'b0, 1'b1);             // evicts slot 0
        start_txn();
        expect_pred(32'h1000, 1'b0, "R10");
        expect_pred(32'h2000, 1'b1, "R10");
        expect_pred(32'h1004, 1'b1, "R10");
        resolve(32'h2004, 1'b0, 1'b1);             // evicts slot 1
        start_txn();
        expect_pred(32'h1004, 1'b0, "R10");
        expect_pred(32'h2004, 1'b1, "R10");
        resolve(32'h1014, 1'b1, 1'b0);             // free slot 5
        resolve(32'h2008, 1'b0, 1'b1);             // fills slot 5
        start_txn();
        expect_pred(32'h1008, 1'b1, "R10");        // rr slot 2 kept
        expect_pred(32'h2008, 1'b1, "R10");
        expect_pred(32'h1014, 1'b0, "R10");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_single_stripe();
        t_multi_stripe();
        t_remove();
        t_flush_and_priority();
        t_replace();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule